// File: doc/BRIEF.md
# Four-Mode 32-Bit Shift Unit

This unit is the shift stage of a load-store processor's execute path. Each cycle it can accept one instruction word, the operand to be shifted (read from the source register) and the value of a second register that may supply the count. One cycle later it presents the shifted word together with a write enable for the destination register. It supports four operations: logical right, arithmetic right, left, and rotate left.

The shift amount has two possible sources. The low five bits of the instruction word form an immediate count field. If that field holds zero, the amount comes from the low five bits of the second register value instead. This lets one encoding serve both constant shifts and shifts by a variable amount. Instruction words whose operation code is not one of the four shift codes are ignored. The register file and the decoding of all other operations lie outside this unit.

Top module: `shift_unit`

## Requirements
- R1: The operation code is instruction bits 31:27. A valid input with code 26, 27, 28 or 29 raises `writeEn` for exactly one cycle, on the clock edge that follows, and `resultOut` carries that operation's result in the same cycle.
- R2: When `inValid` is low, or the operation code is not 26 to 29, `writeEn` stays low on the following cycle and `resultOut` keeps its previous value.
- R3: When instruction bits 4:0 are non-zero, they are the shift count and `countReg` has no effect on the result.
- R4: When instruction bits 4:0 are zero, the count is `countReg` bits 4:0 and bits 31:5 of `countReg` have no effect.
- R5: Code 26 shifts `operandB` right by the count and fills the vacated upper bits with zeros.
- R6: Code 27 shifts `operandB` right by the count and fills the vacated upper bits with copies of `operandB` bit 31. For example, 0x97EAEC16 shifted by 13 gives 0xFFFCBF57.
- R7: Code 28 shifts `operandB` left by the count and fills the vacated lower bits with zeros.
- R8: Code 29 rotates `operandB` left by the count. Bits leaving bit 31 re-enter at bit 0.
- R9: An effective count of zero returns `operandB` unchanged for all four codes.
- R10: While `rstN` is low, `resultOut` is 0 and `writeEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word and operands are valid this cycle |
| instrWord | input | 32 | Instruction word; bits 31:27 hold the operation code, bits 4:0 hold the count field |
| operandB | input | 32 | Word to be shifted |
| countReg | input | 32 | Register value that supplies the count when the count field is zero |
| resultOut | output | 32 | Registered shift result |
| writeEn | output | 1 | Registered destination write enable |

## Verification
The hardest cases to reach are the ones where the two count sources disagree. The instruction field must be non-zero while `countReg` holds a different count, or the field must be zero while `countReg` has junk in its upper bits. Random stimulus seldom separates these, because a random field is zero only about one time in 32. The stimulus therefore chooses between the two count sources on purpose. It sweeps every count from 0 to 31 through each source and for each operation code. It also fills the unused register bits and the middle instruction bits with random values, so that any leak from them changes the result.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int DATA_W  = 32;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 5;
  localparam int OP_LSB  = INSTR_W - OP_W;
  localparam int CNT_W   = $clog2(DATA_W);

  localparam logic [OP_W-1:0] OP_SHIFT_RIGHT = 5'd26;
  localparam logic [OP_W-1:0] OP_SHIFT_ARITH = 5'd27;
  localparam logic [OP_W-1:0] OP_SHIFT_LEFT  = 5'd28;
  localparam logic [OP_W-1:0] OP_ROTATE_LEFT = 5'd29;

  typedef struct packed {
    logic             accept;
    logic             mirror;
    logic             rotate;
    logic             signFill;
    logic [CNT_W-1:0] amount;
  } shift_strobe_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic                inValid,
  input  logic [INSTR_W-1:0]  instrWord,
  input  logic [CNT_W-1:0]    regCount,
  output shift_strobe_t       strobes
);
  logic [OP_W-1:0]  opCode;
  logic [CNT_W-1:0] fieldCount;
  logic             isShift;

  assign opCode     = instrWord[OP_LSB +: OP_W];
  assign fieldCount = instrWord[CNT_W-1:0];

  always_comb begin
    isShift          = 1'b0;
    strobes.mirror   = 1'b0;
    strobes.rotate   = 1'b0;
    strobes.signFill = 1'b0;
    unique case (opCode)
      OP_SHIFT_RIGHT: begin isShift = 1'b1; strobes.mirror = 1'b1; end
      OP_SHIFT_ARITH: begin isShift = 1'b1; strobes.mirror = 1'b1; strobes.signFill = 1'b1; end
      OP_SHIFT_LEFT:  begin isShift = 1'b1; end
      OP_ROTATE_LEFT: begin isShift = 1'b1; strobes.rotate = 1'b1; end
      default: ;
    endcase
    strobes.accept = inValid && isShift;
    strobes.amount = (fieldCount != '0) ? fieldCount : regCount;
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  shift_strobe_t       strobes,
  input  logic [DATA_W-1:0]   operand,
  output logic [DATA_W-1:0]   resultOut,
  output logic                writeEn
);
  logic [DATA_W-1:0] flipped;
  logic [DATA_W-1:0] stage [0:CNT_W];
  logic [DATA_W-1:0] moved [0:CNT_W-1];
  logic [DATA_W-1:0] unflipped;
  logic [DATA_W-1:0] shiftOut;
  logic              fillBit;

  assign fillBit = strobes.signFill & operand[DATA_W-1];

  genvar i, k;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_flipIn
      assign flipped[i] = operand[DATA_W-1-i];
    end
  endgenerate

  assign stage[0] = strobes.mirror ? flipped : operand;

  generate
    for (k = 0; k < CNT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      for (i = 0; i < DATA_W; i++) begin : g_bit
        if (i >= STEP) begin : g_inner
          assign moved[k][i] = stage[k][i-STEP];
        end else begin : g_edge
          assign moved[k][i] = strobes.rotate ? stage[k][i-STEP+DATA_W] : fillBit;
        end
      end
      assign stage[k+1] = strobes.amount[k] ? moved[k] : stage[k];
    end
  endgenerate

  generate
    for (i = 0; i < DATA_W; i++) begin : g_flipOut
      assign unflipped[i] = stage[CNT_W][DATA_W-1-i];
    end
  endgenerate

  assign shiftOut = strobes.mirror ? unflipped : stage[CNT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut <= '0;
      writeEn   <= 1'b0;
    end else begin
      writeEn <= strobes.accept;
      if (strobes.accept) resultOut <= shiftOut;
    end
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [INSTR_W-1:0]  instrWord,
  input  logic [DATA_W-1:0]   operandB,
  input  logic [DATA_W-1:0]   countReg,
  output logic [DATA_W-1:0]   resultOut,
  output logic                writeEn
);
  shift_strobe_t strobes;

  shift_ctrl u_ctrl (
    .inValid  (inValid),
    .instrWord(instrWord),
    .regCount (countReg[CNT_W-1:0]),
    .strobes  (strobes)
  );

  shift_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .operand  (operandB),
    .resultOut(resultOut),
    .writeEn  (writeEn)
  );
endmodule

// File: rtl/shift_unit_checker.sv
module shift_unit_checker
  import shift_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [INSTR_W-1:0]  instrWord,
  input logic [DATA_W-1:0]   operandB,
  input logic [DATA_W-1:0]   countReg,
  input logic [DATA_W-1:0]   resultOut,
  input logic                writeEn
);
  logic [OP_W-1:0]  opSeen;
  logic [CNT_W-1:0] cntSeen;
  logic             shiftSeen;

  assign opSeen    = instrWord[OP_LSB +: OP_W];
  assign cntSeen   = (instrWord[CNT_W-1:0] != '0) ? instrWord[CNT_W-1:0] : countReg[CNT_W-1:0];
  assign shiftSeen = inValid && (opSeen >= OP_SHIFT_RIGHT) && (opSeen <= OP_ROTATE_LEFT);

  // R1: write enable follows a valid shift one cycle later
  p_wen_follows_shift_r1: assert property (@(posedge clk) disable iff (!rstN)
    shiftSeen |=> writeEn);

  // R2: no write enable without a valid shift
  p_no_spurious_wen_r2: assert property (@(posedge clk) disable iff (!rstN)
    !shiftSeen |=> !writeEn);

  // R2: result held when nothing is accepted
  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    !shiftSeen |=> $stable(resultOut));

  // R5: logical right shift by a non-zero count clears bit 31
  p_zero_fill_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (shiftSeen && opSeen == OP_SHIFT_RIGHT && cntSeen != '0) |=> !resultOut[DATA_W-1]);

  // R6: arithmetic right shift keeps the sign bit
  p_sign_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (shiftSeen && opSeen == OP_SHIFT_ARITH) |=> resultOut[DATA_W-1] == $past(operandB[DATA_W-1]));

  // R7: left shift by a non-zero count clears bit 0
  p_zero_fill_lsb_r7: assert property (@(posedge clk) disable iff (!rstN)
    (shiftSeen && opSeen == OP_SHIFT_LEFT && cntSeen != '0) |=> !resultOut[0]);

  // R8: rotation keeps the number of set bits
  p_rotate_popcount_r8: assert property (@(posedge clk) disable iff (!rstN)
    (shiftSeen && opSeen == OP_ROTATE_LEFT) |=> $countones(resultOut) == $countones($past(operandB)));

  // R9: zero count passes the operand through
  p_zero_count_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    (shiftSeen && cntSeen == '0) |=> resultOut == $past(operandB));

  // R10: reset values
  p_reset_state_r10: assert property (@(posedge clk)
    !rstN |=> (resultOut == '0 && !writeEn));
endmodule

bind shift_unit shift_unit_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .instrWord(instrWord),
  .operandB (operandB),
  .countReg (countReg),
  .resultOut(resultOut),
  .writeEn  (writeEn)
);

// File: tb/shift_unit_test.sv
module shift_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] operandB = '0;
  logic [31:0] countReg = '0;
  logic [31:0] resultOut;
  logic        writeEn;

  int totalChecks = 0;
  int failChecks = 0;
  logic [31:0] lastResult = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .operandB(operandB), .countReg(countReg), .resultOut(resultOut), .writeEn(writeEn)
  );

  function automatic logic [31:0] refShift(input logic [4:0] op, input logic [31:0] b, input int n);
    logic [63:0] both;
    if (n == 0) return b;
    case (op)
      5'd26: return b >> n;
      5'd27: return 32'($signed(b) >>> n);
      5'd28: return b << n;
      default: begin
        both = {b, b} << n;
        return both[63:32];
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    totalChecks++;
    if (got !== exp) begin
      failChecks++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Drive one input at a falling edge, check the registered output one edge later.
  task automatic runOp(input string req, input logic v, input logic [4:0] op,
                       input logic [4:0] fld, input logic [31:0] b, input logic [31:0] c);
    logic isShift;
    int   n;
    logic [31:0] expRes;
    isShift   = v && (op >= 5'd26) && (op <= 5'd29);
    n         = (fld != 0) ? int'(fld) : int'(c[4:0]);
    expRes    = isShift ? refShift(op, b, n) : lastResult;
    inValid   = v;
    instrWord = {op, 22'($urandom), fld};
    operandB  = b;
    countReg  = c;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " wen"}, 32'(writeEn), 32'(isShift));
    check({req, " result"}, resultOut, expRes);
    lastResult = expRes;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    totalChecks++;
    failChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10 reset result", resultOut, 32'h0);
    check("R10 reset wen", 32'(writeEn), 32'h0);
    rstN = 1'b1;

    // R6 worked example, count from the field
    runOp("R6 example", 1'b1, 5'd27, 5'd13, 32'h97EAEC16, 32'h0);
    check("R6 example value", resultOut, 32'hFFFCBF57);
    // R5 / R7 / R8 directed
    runOp("R5 logical right", 1'b1, 5'd26, 5'd4, 32'hF000000F, 32'h0);
    check("R5 value", resultOut, 32'h0F000000);
    runOp("R7 left", 1'b1, 5'd28, 5'd31, 32'h00000003, 32'h0);
    check("R7 value", resultOut, 32'h80000000);
    runOp("R8 rotate", 1'b1, 5'd29, 5'd8, 32'h12345678, 32'h0);
    check("R8 value", resultOut, 32'h34567812);
    // R3: field non-zero, register disagrees
    runOp("R3 field wins", 1'b1, 5'd26, 5'd4, 32'h80000000, 32'h0000001F);
    check("R3 value", resultOut, 32'h08000000);
    // R4: field zero, register upper bits are junk
    runOp("R4 reg count", 1'b1, 5'd28, 5'd0, 32'h00000001, 32'hFFFFFFE3);
    check("R4 value", resultOut, 32'h00000008);
    // R9: zero effective count for every code
    for (int op = 26; op <= 29; op++)
      runOp("R9 zero count", 1'b1, 5'(op), 5'd0, 32'hA5C3_0F96, 32'hFFFF_FFE0);
    // R2: non-shift code and invalid shift leave the output alone
    runOp("R2 non-shift code", 1'b1, 5'd12, 5'd3, 32'hDEADBEEF, 32'h5);
    runOp("R2 idle valid low", 1'b0, 5'd28, 5'd3, 32'hDEADBEEF, 32'h5);
    runOp("R2 stop code", 1'b1, 5'd31, 5'd0, 32'h1, 32'h1);
    // R1 back to back pulses, then a gap
    runOp("R1 back to back a", 1'b1, 5'd27, 5'd1, 32'h80000000, 32'h0);
    runOp("R1 back to back b", 1'b1, 5'd27, 5'd0, 32'h80000000, 32'h7);
    runOp("R1 single pulse", 1'b0, 5'd0, 5'd0, 32'h0, 32'h0);

    // Sweep every count through both sources for each code (R3 R4 R5 R6 R7 R8)
    for (int op = 26; op <= 29; op++) begin
      for (int n = 0; n < 32; n++) begin
        runOp("R3 sweep field", 1'b1, 5'(op), 5'(n), $urandom, $urandom);
        runOp("R4 sweep reg", 1'b1, 5'(op), 5'd0, $urandom, {27'($urandom), 5'(n)});
      end
    end

    // Constrained random mix (R1 R2)
    for (int t = 0; t < 400; t++) begin
      logic [4:0] op;
      logic [4:0] fld;
      op  = ($urandom % 8 == 0) ? 5'($urandom) : 5'(26 + $urandom % 4);
      fld = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      runOp("R1 random", ($urandom % 6) != 0, op, fld, $urandom, $urandom);
    end

    $display("  %0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end
endmodule